// File: doc/BRIEF.md
# Bus-Snooping Shadow RAM Coherency Writer

This block sits on the host bus of a system whose main RAM is mirrored by a fast shadow copy. It never drives the bus. It watches every bus cycle and turns the writes that other bus masters make into main RAM into matching writes to the shadow. The CPU then reads the shadow without ever finding stale data.

There are two kinds of foreign writer. The first is a master that drives its own address, such as a block-copy engine. Its writes are copied into the shadow at the address seen on the bus. The second is the disk DMA channel. The memory controller addresses RAM from internal registers, so the address lines float high during those cycles. For these transfers the block keeps a local copy of the controller's DMA pointer. It loads that copy by snooping CPU byte writes to the pointer registers and steps it by two on every DMA word. The data word is taken from the data bus during the transfer itself.

A DMA cycle is recognised in one of two ways, chosen by a parameter. It can come from a dedicated select input. It can also be inferred: the bus is granted away from the CPU, all address lines read high, and a data strobe is active.

Top module: `shadow_snoop_sync`

## Requirements
- R1: After synchronous reset, `sh_we`, `sh_addr`, `sh_data` and `sh_be` are all zero, and the local DMA pointer is zero.
- R2: A bus cycle is counted when the data strobe (`bus_uds` or `bus_lds`) rises. Take such a cycle with `bus_granted`=1 and `bus_we`=1 that is not a DMA cycle. It raises `sh_we` on the next clock edge. `sh_addr` is the bus address with bit 0 cleared, `sh_data` is `bus_data`, and `sh_be` is {`bus_uds`,`bus_lds`}, where bit 1 is the upper lane.
- R3: Each rise of the data strobe yields at most one `sh_we` pulse, one clock long, however long the strobe is held.
- R4: A CPU write (`bus_granted`=0, `bus_we`=1, `bus_lds`=1) to word address REG_BASE, REG_BASE+2 or REG_BASE+4 loads `bus_data[7:0]` into pointer bits [7:0], [15:8] or [23:16] respectively. It produces no shadow write.
- R5: A DMA cycle with `dma_to_mem`=1 writes `bus_data` at the pointer (bit 0 cleared) with `sh_be`=2'b11. The pointer then advances by 2.
- R6: A DMA cycle with `dma_to_mem`=0 produces no shadow write, but the pointer still advances by 2.
- R7: With USE_DMA_SEL=1 a cycle is DMA when `dma_sel`=1. With USE_DMA_SEL=0 it is DMA when `bus_granted`=1 and `bus_addr` is all ones, and `dma_sel` is ignored.
- R8: A write whose word address falls outside [RAM_BASE, RAM_BASE+RAM_BYTES) raises no `sh_we`. A DMA pointer still advances in that case.
- R9: A pointer register write made between transfers of a running DMA burst takes effect from the very next transfer.
- R10: A granted read, a CPU write to any other address, and a pointer register write on the upper lane only all leave both the shadow and the pointer untouched.
- R11: The pointer wraps modulo 2^24 on advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Host bus byte address (floats high during DMA) |
| bus_data | input | 16 | Host bus data |
| bus_uds | input | 1 | Upper data strobe, active high |
| bus_lds | input | 1 | Lower data strobe, active high |
| bus_we | input | 1 | Bus cycle is a write |
| bus_granted | input | 1 | Bus is granted away from the CPU |
| dma_sel | input | 1 | DMA cycle select (used when USE_DMA_SEL=1) |
| dma_to_mem | input | 1 | DMA direction: 1 = device into memory |
| sh_we | output | 1 | Shadow write strobe, one clock |
| sh_addr | output | 24 | Shadow write byte address, word aligned |
| sh_data | output | 16 | Shadow write data |
| sh_be | output | 2 | Shadow byte enables {upper, lower} |

## Verification
The assertions rely on the bus being synchronous to `clk` and on each strobe assertion belonging to a single bus cycle. In other words, address, data and the control inputs stay stable for as long as a strobe is high. The bench drives every input at the falling edge and holds it over a whole strobe pulse. It drops the strobe for at least one cycle between cycles, so every bus cycle produces exactly one rising strobe edge. The bench runs two instances, one per recognition mode. It includes cycles on which the select input and the all-ones address disagree, to show where the two modes differ.

// File: rtl/shsnoop_pkg.sv
package shsnoop_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_MASTER = 2'd1,
    EV_DMA    = 2'd2,
    EV_REGWR  = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/snoop_bus_decode.sv
module snoop_bus_decode
  import shsnoop_pkg::*;
#(
  parameter int AW          = 24,
  parameter bit USE_DMA_SEL = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_uds,
  input  logic          bus_lds,
  input  logic          bus_we,
  input  logic          bus_granted,
  input  logic          dma_sel,
  output ev_kind_e      ev_kind
);
  logic strobe, strobe_q, strobe_rise, dma_hit;

  assign strobe      = bus_uds | bus_lds;
  assign strobe_rise = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  generate
    if (USE_DMA_SEL) begin : g_sel
      assign dma_hit = dma_sel;
    end else begin : g_infer
      assign dma_hit = bus_granted & (&bus_addr) & strobe;
    end
  endgenerate

  always_comb begin
    ev_kind = EV_NONE;
    if (strobe_rise) begin
      if (dma_hit)                    ev_kind = EV_DMA;
      else if (bus_granted && bus_we) ev_kind = EV_MASTER;
      else if (!bus_granted && bus_we) ev_kind = EV_REGWR;
    end
  end

  // R3: an event needs a fresh strobe edge, so two never come back to back
  p_event_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (ev_kind != EV_NONE) |=> (ev_kind == EV_NONE));
endmodule

// File: rtl/dma_ptr_track.sv
module dma_ptr_track
  import shsnoop_pkg::*;
#(
  parameter int          AW       = 24,
  parameter int          DW       = 16,
  parameter int unsigned REG_BASE = 32'h00FF_8700
) (
  input  logic          clk,
  input  logic          rst,
  input  ev_kind_e      ev_kind,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_lds,
  output logic [AW-1:0] ptr
);
  localparam int PTR_BYTES = AW / 8;
  localparam int STEP      = DW / 8;

  logic [PTR_BYTES-1:0] byte_hit;
  logic [AW-1:0]        ptr_nxt;

  generate
    for (genvar i = 0; i < PTR_BYTES; i++) begin : g_reg
      localparam logic [AW-1:0] REG_ADDR = AW'(REG_BASE + 2 * i);
      assign byte_hit[i] = (ev_kind == EV_REGWR) && bus_lds &&
                           (bus_addr[AW-1:1] == REG_ADDR[AW-1:1]);
    end
  endgenerate

  always_comb begin
    ptr_nxt = ptr;
    if (ev_kind == EV_DMA) begin
      ptr_nxt = ptr + AW'(STEP);
    end else begin
      for (int i = 0; i < PTR_BYTES; i++)
        if (byte_hit[i]) ptr_nxt[8*i +: 8] = bus_data[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptr_nxt;
  end

  // R5/R6: every DMA word moves the pointer by one word
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_DMA) |=> (ptr == $past(ptr) + AW'(STEP)));
  // R10: with no event the pointer holds
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_NONE) |=> $stable(ptr));
  // R10: granted masters never touch the pointer
  p_master_no_ptr_r10: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_MASTER) |=> $stable(ptr));
endmodule

// File: rtl/shadow_wr_port.sv
module shadow_wr_port
  import shsnoop_pkg::*;
#(
  parameter int          AW        = 24,
  parameter int          DW        = 16,
  parameter int unsigned RAM_BASE  = 32'h0000_0000,
  parameter int unsigned RAM_BYTES = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  ev_kind_e        ev_kind,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_data,
  input  logic            bus_uds,
  input  logic            bus_lds,
  input  logic            dma_to_mem,
  input  logic [AW-1:0]   ptr,
  output logic            sh_we,
  output logic [AW-1:0]   sh_addr,
  output logic [DW-1:0]   sh_data,
  output logic [DW/8-1:0] sh_be
);
  localparam int            BEW    = DW / 8;
  localparam logic [AW:0]   RAM_LO = (AW+1)'(RAM_BASE);
  localparam logic [AW:0]   RAM_HI = (AW+1)'(RAM_BASE + RAM_BYTES);

  logic [AW-1:0]  wr_addr;
  logic [BEW-1:0] wr_be;
  logic           want, in_range, go;

  always_comb begin
    wr_addr = (ev_kind == EV_DMA) ? ptr : bus_addr;
    wr_addr[0] = 1'b0;
    wr_be   = (ev_kind == EV_DMA) ? {BEW{1'b1}} : {bus_uds, bus_lds};
    want    = (ev_kind == EV_MASTER) || ((ev_kind == EV_DMA) && dma_to_mem);
  end

  assign in_range = ({1'b0, wr_addr} >= RAM_LO) && ({1'b0, wr_addr} < RAM_HI);
  assign go       = want && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_we   <= 1'b0;
      sh_addr <= '0;
      sh_data <= '0;
      sh_be   <= '0;
    end else begin
      sh_we <= go;
      if (go) begin
        sh_addr <= wr_addr;
        sh_data <= bus_data;
        sh_be   <= wr_be;
      end
    end
  end

  // R3: a shadow strobe lasts exactly one clock
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    sh_we |=> !sh_we);
  // R8: no strobe leaves the shadowed window
  p_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    sh_we |-> (({1'b0, sh_addr} >= RAM_LO) && ({1'b0, sh_addr} < RAM_HI)));
  // R5: DMA words always carry both lanes
  p_dma_full_word_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_DMA && go) |=> (sh_we && sh_be == {BEW{1'b1}}));
  // R6: memory-to-device DMA leaves the shadow alone
  p_dir_read_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_DMA && !dma_to_mem) |=> !sh_we);
  // R4: pointer register writes never reach the shadow
  p_regwr_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_kind == EV_REGWR) |=> !sh_we);
endmodule

// File: rtl/shadow_snoop_sync.sv
module shadow_snoop_sync
  import shsnoop_pkg::*;
#(
  parameter int          AW          = 24,
  parameter int          DW          = 16,
  parameter bit          USE_DMA_SEL = 1'b1,
  parameter int unsigned REG_BASE    = 32'h00FF_8700,
  parameter int unsigned RAM_BASE    = 32'h0000_0000,
  parameter int unsigned RAM_BYTES   = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_data,
  input  logic            bus_uds,
  input  logic            bus_lds,
  input  logic            bus_we,
  input  logic            bus_granted,
  input  logic            dma_sel,
  input  logic            dma_to_mem,
  output logic            sh_we,
  output logic [AW-1:0]   sh_addr,
  output logic [DW-1:0]   sh_data,
  output logic [DW/8-1:0] sh_be
);
  ev_kind_e      ev_kind;
  logic [AW-1:0] ptr;

  snoop_bus_decode #(.AW(AW), .USE_DMA_SEL(USE_DMA_SEL)) u_decode (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_uds(bus_uds),
    .bus_lds(bus_lds), .bus_we(bus_we), .bus_granted(bus_granted),
    .dma_sel(dma_sel), .ev_kind(ev_kind)
  );

  dma_ptr_track #(.AW(AW), .DW(DW), .REG_BASE(REG_BASE)) u_ptr (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_lds(bus_lds), .ptr(ptr)
  );

  shadow_wr_port #(.AW(AW), .DW(DW), .RAM_BASE(RAM_BASE),
                   .RAM_BYTES(RAM_BYTES)) u_wr (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_uds(bus_uds), .bus_lds(bus_lds),
    .dma_to_mem(dma_to_mem), .ptr(ptr), .sh_we(sh_we),
    .sh_addr(sh_addr), .sh_data(sh_data), .sh_be(sh_be)
  );

  // R1: outputs come out of reset quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!sh_we && sh_addr == '0 && sh_be == '0));
  // R2: a strobe follows only a granted write or a DMA cycle
  p_strobe_cause_r2: assert property (@(posedge clk) disable iff (rst)
    sh_we |-> ($past(ev_kind) == EV_MASTER || $past(ev_kind) == EV_DMA));
endmodule

// File: tb/tb_shadow_snoop_sync.sv
module tb_shadow_snoop_sync;
  localparam int unsigned REG_BASE  = 32'h00FF_8700;
  localparam int unsigned RAM_BYTES = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_uds = 0, bus_lds = 0, bus_we = 0, bus_granted = 0;
  logic        dma_sel = 0, dma_to_mem = 0;

  logic        o_we[2];
  logic [23:0] o_addr[2];
  logic [15:0] o_data[2];
  logic [1:0]  o_be[2];

  always #2 clk = ~clk;

  shadow_snoop_sync #(.USE_DMA_SEL(1'b1), .REG_BASE(REG_BASE), .RAM_BYTES(RAM_BYTES)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_we(bus_we),
    .bus_granted(bus_granted), .dma_sel(dma_sel), .dma_to_mem(dma_to_mem),
    .sh_we(o_we[0]), .sh_addr(o_addr[0]), .sh_data(o_data[0]), .sh_be(o_be[0]));

  shadow_snoop_sync #(.USE_DMA_SEL(1'b0), .REG_BASE(REG_BASE), .RAM_BYTES(RAM_BYTES)) dut_inf (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_we(bus_we),
    .bus_granted(bus_granted), .dma_sel(dma_sel), .dma_to_mem(dma_to_mem),
    .sh_we(o_we[1]), .sh_addr(o_addr[1]), .sh_data(o_data[1]), .sh_be(o_be[1]));

  int total = 0;
  int bad = 0;
  string scen = "R1 reset";
  bit running = 0;

  // behavioural reference model
  int unsigned mptr[2];
  bit          mprev;
  bit          ewe[2];
  int unsigned eaddr[2];
  int unsigned edata[2];
  int unsigned ebe[2];
  bit          m_ds, m_rise, m_dma;
  int unsigned m_a, m_word;

  always @(posedge clk) begin
    if (rst) begin
      mprev = 0;
      for (int v = 0; v < 2; v++) begin
        mptr[v] = 0; ewe[v] = 0;
      end
    end else begin
      m_ds   = bus_uds | bus_lds;
      m_rise = m_ds && !mprev;
      mprev  = m_ds;
      for (int v = 0; v < 2; v++) begin
        ewe[v] = 0;
        if (m_rise) begin
          m_dma = (v == 0) ? dma_sel : (bus_granted && bus_addr == 24'hFFFFFF);
          if (m_dma) begin
            m_a = mptr[v] & 32'hFFFFFE;
            if (dma_to_mem && m_a < RAM_BYTES) begin
              ewe[v] = 1; eaddr[v] = m_a; edata[v] = bus_data; ebe[v] = 3;
            end
            mptr[v] = (mptr[v] + 2) & 32'hFFFFFF;
          end else if (bus_granted && bus_we) begin
            m_a = bus_addr & 32'hFFFFFE;
            if (m_a < RAM_BYTES) begin
              ewe[v] = 1; eaddr[v] = m_a; edata[v] = bus_data;
              ebe[v] = {bus_uds, bus_lds};
            end
          end else if (!bus_granted && bus_we && bus_lds) begin
            m_word = bus_addr >> 1;
            for (int i = 0; i < 3; i++)
              if (m_word == ((REG_BASE + 2 * i) >> 1))
                mptr[v] = (mptr[v] & ~(32'hFF << (8 * i))) | (int'(bus_data[7:0]) << (8 * i));
          end
        end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      for (int v = 0; v < 2; v++) begin
        total++;
        if (o_we[v] !== ewe[v] ||
            (ewe[v] && (o_addr[v] !== eaddr[v][23:0] || o_data[v] !== edata[v][15:0] ||
                        o_be[v] !== ebe[v][1:0]))) begin
          bad++;
          $display("FAIL %s inst=%0d got we=%0b addr=%h data=%h be=%b exp we=%0b addr=%h data=%h be=%b",
                   scen, v, o_we[v], o_addr[v], o_data[v], o_be[v],
                   ewe[v], eaddr[v][23:0], edata[v][15:0], ebe[v][1:0]);
        end
      end
    end
  end

  task automatic cyc(input bit g, input bit we, input logic [23:0] a, input logic [15:0] d,
                     input bit u, input bit l, input bit sel, input bit dir, input int hold);
    @(negedge clk);
    bus_granted = g; bus_we = we; bus_addr = a; bus_data = d;
    dma_sel = sel; dma_to_mem = dir; bus_uds = u; bus_lds = l;
    repeat (hold) @(negedge clk);
    bus_uds = 0; bus_lds = 0; dma_sel = 0;
    @(negedge clk);
    bus_granted = 0; bus_we = 0; bus_addr = '0;
  endtask

  task automatic mwr(input logic [23:0] a, input logic [15:0] d, input bit u, input bit l);
    cyc(1, 1, a, d, u, l, 0, 0, 1);
  endtask
  task automatic regwr(input int idx, input logic [7:0] b);
    cyc(0, 1, 24'(REG_BASE + 2 * idx), {8'h00, b}, 0, 1, 0, 0, 1);
  endtask
  task automatic setptr(input logic [23:0] p);
    regwr(2, p[23:16]); regwr(1, p[15:8]); regwr(0, p[7:0]);
  endtask
  task automatic dma(input logic [15:0] d, input bit dir);
    cyc(1, dir, 24'hFFFFFF, d, 1, 1, 1, dir, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      total++;
      if (o_we[v] !== 0 || o_addr[v] !== 0 || o_data[v] !== 0 || o_be[v] !== 0) begin
        bad++;
        $display("FAIL R1 inst=%0d got we=%0b addr=%h be=%b exp all zero", v, o_we[v], o_addr[v], o_be[v]);
      end
    end
    running = 1;
    scen = "R2 master word";   mwr(24'h001000, 16'hA5A5, 1, 1);
    scen = "R2 master upper";  mwr(24'h001003, 16'h1234, 1, 0);
    scen = "R2 master lower";  mwr(24'h002001, 16'h5678, 0, 1);
    scen = "R3 long strobe";   cyc(1, 1, 24'h003000, 16'hBEEF, 1, 1, 0, 0, 6);
    scen = "R10 granted read"; cyc(1, 0, 24'h004000, 16'h1111, 1, 1, 0, 0, 1);
    scen = "R8 master above";  mwr(24'h400000, 16'h2222, 1, 1);
    scen = "R8 master top";    mwr(24'h3FFFFE, 16'h3333, 1, 1);
    scen = "R4 pointer load";  setptr(24'h012340);
    scen = "R5 dma burst";
    for (int k = 0; k < 4; k++) dma(16'hC000 + 16'(k), 1);
    scen = "R6 dma to device";
    dma(16'hD000, 0); dma(16'hD001, 0);
    scen = "R6 dma resume";    dma(16'hD002, 1);
    scen = "R9 mid-burst low"; regwr(0, 8'h80);
    dma(16'hE000, 1); dma(16'hE001, 1);
    scen = "R10 upper lane reg"; cyc(0, 1, 24'(REG_BASE), 16'h4400, 1, 0, 0, 0, 1);
    scen = "R10 other cpu wr";   cyc(0, 1, 24'h000100, 16'h0055, 0, 1, 0, 0, 1);
    scen = "R10 ptr unchanged";  dma(16'hE002, 1);
    scen = "R7 select no ones";  cyc(1, 1, 24'h000200, 16'hF00D, 1, 1, 1, 1, 1);
    scen = "R7 ones no select";  cyc(1, 1, 24'hFFFFFF, 16'hF00E, 1, 1, 0, 1, 1);
    scen = "R7 after split";     dma(16'hF00F, 1);
    scen = "R8 dma above ram";   setptr(24'h3FFFFE); dma(16'h0A0A, 1); dma(16'h0B0B, 1);
    scen = "R11 wrap";           setptr(24'hFFFFFE); dma(16'h0C0C, 1);
    scen = "R11 after wrap";     dma(16'h0D0D, 1);
    scen = "R2 back to back";    mwr(24'h000010, 16'h7777, 1, 1); mwr(24'h000012, 16'h8888, 1, 1);
    repeat (3) @(negedge clk);
    running = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule